// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller moves a processor subsystem between three power modes: Run, Wait and Stop. The core asks for Wait or Stop by raising a request line. The controller acts on that request only when the core reports that no stall or hold-off is in progress and the matching disable bit is clear. In Wait, only the core clock is gated, so the system clocks keep running and a DMA engine can continue to move data. In Stop, the core clock, the system clocks and the peripheral bus clock are all gated.

Stop entry comes in two flavours, chosen by a configuration input. In the ultra-low-power flavour, the controller puts the PLL into shutdown/bypass on the entry cycle and puts the oscillator into low-power one cycle after that. On exit it releases the oscillator first, releases the PLL one cycle later, and turns the clocks back on only after a programmable settle count. In the fast-recovery flavour, the PLL and oscillator controls are never touched.

Three asynchronous sources wake the block: a pending enabled interrupt, a debug request from the scan port, and a debug-entry pin. Each one passes through a two-flop synchronizer before it is used. A wake that arrives while a Stop entry is still being sequenced aborts that entry and returns the block to Run. The time-base clock and the pad pull settings are not under this block's control.

Top module: `pm_mode_ctrl`

## Requirements
- R1: After reset, the block is in Run with `mode`=2'b00. All three clock enables are 1, and `pll_shutdown` and `osc_lowpwr` are 0.
- R2: While `core_stall` is 1, no stop or wait request is taken and `mode` stays 2'b00. A request that is still held is taken on the first clock edge after `core_stall` falls.
- R3: In Wait (`mode`=2'b01), `core_clk_en` is 0 and `sys_clk_en` and `pbus_clk_en` are 1.
- R4: In Stop (`mode`=2'b10), this includes its entry and exit sequencing, all three clock enables are 0.
- R5: When `stop_dis` is 1, a stop request is ignored. When `wait_dis` is 1, a wait request is ignored. In both cases `mode` stays 2'b00 and all clocks stay enabled.
- R6: When `fast_stop`=0, `pll_shutdown` rises on the clock edge that enters Stop. `osc_lowpwr` rises on the next edge.
- R7: On wake from ultra-low-power Stop, `osc_lowpwr` falls first while `pll_shutdown` stays 1. `pll_shutdown` falls one edge later. The block returns to Run `settle_cycles`+1 edges after that, with the clocks still gated until then.
- R8: When `fast_stop`=1, `pll_shutdown` and `osc_lowpwr` stay 0 throughout Stop. A wake returns the block directly to Run.
- R9: A wake from any one of `wake_irq`, `wake_dbg_scan` or `wake_dbg_pin` ends Wait or Stop.
- R10: Each wake input goes through two synchronizer flops. A wake that is set up before clock edge k changes the mode at edge k+2, and not earlier.
- R11: A synchronized wake seen during the Stop entry cycle aborts the entry. The block returns to Run on the next edge, and `osc_lowpwr` is never raised.
- R12: When stop and wait requests are both valid in the same cycle, Stop is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Core requests Stop |
| wait_req | input | 1 | Core requests Wait |
| core_stall | input | 1 | Core stall / hold-off in progress |
| stop_dis | input | 1 | Ignore stop requests |
| wait_dis | input | 1 | Ignore wait requests |
| fast_stop | input | 1 | 1: fast-recovery Stop, 0: ultra-low-power Stop |
| settle_cycles | input | SETTLE_W | Clock settle count used on ultra-low-power exit |
| wake_irq | input | 1 | Async wake: pending enabled interrupt |
| wake_dbg_scan | input | 1 | Async wake: scan-port debug request |
| wake_dbg_pin | input | 1 | Async wake: debug-entry pin |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clocks enable |
| pbus_clk_en | output | 1 | Peripheral bus clock enable |
| pll_shutdown | output | 1 | PLL shutdown and bypass |
| osc_lowpwr | output | 1 | Oscillator low-power control |
| mode | output | 2 | Current mode: 00 Run, 01 Wait, 10 Stop |

## Verification
Directed sequences cover the following cases:
- A request held under a stall, which separates correct stall gating from early entry.
- Requests with the disable bits set, which shows whether a disabled request is really ignored.
- Simultaneous stop and wait requests, which exposes the priority.
- Both Stop flavours, which tells apart the PLL/oscillator ordering on entry and exit, including the settle count.
- A wake timed onto the entry cycle, which exercises the abort path.

Each wake source is used on its own, and the cycle in which the mode changes is checked, so that a missing or extra synchronizer stage shows up. Seeded random traffic then mixes stalls, requests, disable bits, flavours, settle counts and wakes. It is compared every cycle against a reference model that the bench builds from the requirements.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    PM_RUN      = 3'd0,
    PM_WAIT     = 3'd1,
    PM_STOP_ENT = 3'd2,
    PM_STOP     = 3'd3,
    PM_EXIT_OSC = 3'd4,
    PM_EXIT_PLL = 3'd5
  } pm_state_e;

  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_WAIT = 2'b01;
  localparam logic [1:0] MODE_STOP = 2'b10;

  localparam int NUM_WAKE = 3;
endpackage

// File: rtl/pm_wake_sync.sv
module pm_wake_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign sync_out = stg[LAST];
endmodule

// File: rtl/pm_settle_timer.sv
module pm_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  output logic                done
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pm_seq_fsm.sv
module pm_seq_fsm
  import pm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stop_req,
  input  logic      wait_req,
  input  logic      core_stall,
  input  logic      stop_dis,
  input  logic      wait_dis,
  input  logic      fast_stop,
  input  logic      wake_any,
  input  logic      settle_done,
  output pm_state_e state,
  output logic      ulp_q,
  output logic      settle_load
);
  pm_state_e nxt;
  logic      stop_ok, wait_ok;

  assign stop_ok = stop_req && !stop_dis && !core_stall;
  assign wait_ok = wait_req && !wait_dis && !core_stall;

  always_comb begin
    nxt = state;
    unique case (state)
      PM_RUN: begin
        if (!wake_any) begin
          if (stop_ok)      nxt = PM_STOP_ENT;
          else if (wait_ok) nxt = PM_WAIT;
        end
      end
      PM_WAIT:     if (wake_any) nxt = PM_RUN;
      PM_STOP_ENT: nxt = wake_any ? PM_RUN : PM_STOP;
      PM_STOP: begin
        if (wake_any) nxt = ulp_q ? PM_EXIT_OSC : PM_RUN;
      end
      PM_EXIT_OSC: nxt = PM_EXIT_PLL;
      PM_EXIT_PLL: if (settle_done) nxt = PM_RUN;
      default:     nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PM_RUN;
      ulp_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == PM_RUN && nxt == PM_STOP_ENT) ulp_q <= !fast_stop;
    end
  end

  assign settle_load = (state == PM_EXIT_OSC);
endmodule

// File: rtl/pm_out_decode.sv
module pm_out_decode
  import pm_pkg::*;
(
  input  pm_state_e  state,
  input  logic       ulp,
  output logic       core_clk_en,
  output logic       sys_clk_en,
  output logic       pbus_clk_en,
  output logic       pll_shutdown,
  output logic       osc_lowpwr,
  output logic [1:0] mode
);
  always_comb begin
    core_clk_en  = 1'b1;
    sys_clk_en   = 1'b1;
    pbus_clk_en  = 1'b1;
    pll_shutdown = 1'b0;
    osc_lowpwr   = 1'b0;
    mode         = MODE_RUN;
    unique case (state)
      PM_RUN: ;
      PM_WAIT: begin
        core_clk_en = 1'b0;
        mode        = MODE_WAIT;
      end
      default: begin
        core_clk_en = 1'b0;
        sys_clk_en  = 1'b0;
        pbus_clk_en = 1'b0;
        mode        = MODE_STOP;
        case (state)
          PM_STOP_ENT: pll_shutdown = ulp;
          PM_STOP: begin
            pll_shutdown = ulp;
            osc_lowpwr   = ulp;
          end
          PM_EXIT_OSC: pll_shutdown = 1'b1;
          default: ;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/pm_mode_ctrl.sv
module pm_mode_ctrl
  import pm_pkg::*;
#(
  parameter int SETTLE_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_req,
  input  logic                wait_req,
  input  logic                core_stall,
  input  logic                stop_dis,
  input  logic                wait_dis,
  input  logic                fast_stop,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                wake_irq,
  input  logic                wake_dbg_scan,
  input  logic                wake_dbg_pin,
  output logic                core_clk_en,
  output logic                sys_clk_en,
  output logic                pbus_clk_en,
  output logic                pll_shutdown,
  output logic                osc_lowpwr,
  output logic [1:0]          mode
);
  logic [NUM_WAKE-1:0] wake_sync;
  logic                wake_any, settle_done, settle_load, ulp_q;
  pm_state_e           state;

  pm_wake_sync #(.WIDTH(NUM_WAKE), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({wake_dbg_pin, wake_dbg_scan, wake_irq}),
    .sync_out (wake_sync)
  );

  assign wake_any = |wake_sync;

  pm_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (settle_load),
    .load_val (settle_cycles),
    .done     (settle_done)
  );

  pm_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .wait_req    (wait_req),
    .core_stall  (core_stall),
    .stop_dis    (stop_dis),
    .wait_dis    (wait_dis),
    .fast_stop   (fast_stop),
    .wake_any    (wake_any),
    .settle_done (settle_done),
    .state       (state),
    .ulp_q       (ulp_q),
    .settle_load (settle_load)
  );

  pm_out_decode u_dec (
    .state        (state),
    .ulp          (ulp_q),
    .core_clk_en  (core_clk_en),
    .sys_clk_en   (sys_clk_en),
    .pbus_clk_en  (pbus_clk_en),
    .pll_shutdown (pll_shutdown),
    .osc_lowpwr   (osc_lowpwr),
    .mode         (mode)
  );
endmodule

// File: rtl/pm_mode_ctrl_chk.sv
module pm_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       core_stall,
  input logic       stop_dis,
  input logic       wait_dis,
  input logic       fast_stop,
  input logic       core_clk_en,
  input logic       sys_clk_en,
  input logic       pbus_clk_en,
  input logic       pll_shutdown,
  input logic       osc_lowpwr,
  input logic [1:0] mode
);
  // R1: the mode code is always one of the three legal values
  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  // R2: no entry while the core is stalled
  a_r2_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && core_stall) |=> mode == 2'b00);

  // R3: Wait gates only the core clock
  a_r3_wait_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (!core_clk_en && sys_clk_en && pbus_clk_en));

  // R4: Stop gates every clock
  a_r4_stop_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (!core_clk_en && !sys_clk_en && !pbus_clk_en));

  // R5: both disables set keeps the block in Run
  a_r5_disabled_run: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && stop_dis && wait_dis) |=> mode == 2'b00);

  // R6: oscillator low-power only rises behind an asserted PLL shutdown
  a_r6_osc_after_pll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_lowpwr) |-> $past(pll_shutdown) && pll_shutdown);

  // R7: PLL shutdown releases only after the oscillator is out of low power
  a_r7_osc_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_shutdown) |-> !osc_lowpwr && !$past(osc_lowpwr));

  // R8: fast-recovery stop never drives the PLL or oscillator controls
  a_r8_fast_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && fast_stop) |=> !pll_shutdown && !osc_lowpwr);
endmodule

bind pm_mode_ctrl pm_mode_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_stall   (core_stall),
  .stop_dis     (stop_dis),
  .wait_dis     (wait_dis),
  .fast_stop    (fast_stop),
  .core_clk_en  (core_clk_en),
  .sys_clk_en   (sys_clk_en),
  .pbus_clk_en  (pbus_clk_en),
  .pll_shutdown (pll_shutdown),
  .osc_lowpwr   (osc_lowpwr),
  .mode         (mode)
);

// File: tb/tb_pm_mode_ctrl.sv
module tb_pm_mode_ctrl;
  localparam int SW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_req = 0, wait_req = 0, core_stall = 0, stop_dis = 0, wait_dis = 0, fast_stop = 0;
  logic [SW-1:0] settle_cycles = '0;
  logic wake_irq = 0, wake_dbg_scan = 0, wake_dbg_pin = 0;
  logic core_clk_en, sys_clk_en, pbus_clk_en, pll_shutdown, osc_lowpwr;
  logic [1:0] mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pm_mode_ctrl #(.SETTLE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
    .core_stall(core_stall), .stop_dis(stop_dis), .wait_dis(wait_dis),
    .fast_stop(fast_stop), .settle_cycles(settle_cycles), .wake_irq(wake_irq),
    .wake_dbg_scan(wake_dbg_scan), .wake_dbg_pin(wake_dbg_pin),
    .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en), .pbus_clk_en(pbus_clk_en),
    .pll_shutdown(pll_shutdown), .osc_lowpwr(osc_lowpwr), .mode(mode));

  // Reference model (states: 0 run, 1 wait, 2 stop entry, 3 stop, 4 osc release, 5 pll release/settle)
  int m_st = 0, m_cnt = 0;
  bit m_ulp = 0, m_s1 = 0, m_s2 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_ulp <= 0; m_s1 <= 0; m_s2 <= 0;
    end else begin
      m_s1 <= wake_irq | wake_dbg_scan | wake_dbg_pin;
      m_s2 <= m_s1;
      case (m_st)
        0: if (!m_s2) begin
             if (stop_req && !stop_dis && !core_stall) begin m_st <= 2; m_ulp <= !fast_stop; end
             else if (wait_req && !wait_dis && !core_stall) m_st <= 1;
           end
        1: if (m_s2) m_st <= 0;
        2: m_st <= m_s2 ? 0 : 3;
        3: if (m_s2) m_st <= m_ulp ? 4 : 0;
        4: begin m_st <= 5; m_cnt <= int'(settle_cycles); end
        default: if (m_cnt == 0) m_st <= 0; else m_cnt <= m_cnt - 1;
      endcase
    end
  end

  // packed {core, sys, pbus, pll, osc, mode[1:0]}
  function automatic logic [6:0] exp_out(int st, bit ulp);
    case (st)
      0: return 7'b111_00_00;
      1: return 7'b011_00_01;
      2: return {3'b000, ulp, 1'b0, 2'b10};
      3: return {3'b000, ulp, ulp, 2'b10};
      4: return 7'b000_10_10;
      default: return 7'b000_00_10;
    endcase
  endfunction

  function automatic logic [6:0] act_out();
    return {core_clk_en, sys_clk_en, pbus_clk_en, pll_shutdown, osc_lowpwr, mode};
  endfunction

  function automatic string tag_of(logic [6:0] a, logic [6:0] e);
    if (a[1:0] != e[1:0]) return "R9/R10 mode";
    if (a[6:4] != e[6:4]) return "R3/R4 clocks";
    return "R6/R7/R8 pll-osc";
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) check(tag_of(act_out(), exp_out(m_st, m_ulp)), act_out(), exp_out(m_st, m_ulp));
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    @(negedge clk); @(negedge clk);
    check("R1 reset", act_out(), 7'b111_00_00);
    rst_n = 1;
    tick();
    check("R1 after reset", act_out(), 7'b111_00_00);

    // R2 stall holds off request, then R3 wait
    wait_req = 1; core_stall = 1; tick(2);
    check("R2 stalled", act_out(), 7'b111_00_00);
    core_stall = 0; tick();
    check("R3 wait entry", act_out(), 7'b011_00_01);
    wait_req = 0;
    // R10 two-stage sync, R9 interrupt wake
    wake_irq = 1; tick();
    check("R10 sync stage1", act_out(), 7'b011_00_01);
    tick();
    check("R10 sync stage2", act_out(), 7'b011_00_01);
    tick();
    check("R9 irq wake", act_out(), 7'b111_00_00);
    wake_irq = 0; tick(3);

    // R5 disable bits
    wait_dis = 1; wait_req = 1; tick(2);
    check("R5 wait disabled", act_out(), 7'b111_00_00);
    wait_req = 0; stop_dis = 1; stop_req = 1; tick(2);
    check("R5 stop disabled", act_out(), 7'b111_00_00);
    stop_req = 0; stop_dis = 0; wait_dis = 0;

    // R12 priority, R4/R6 ultra-low-power entry
    settle_cycles = 8'd3; fast_stop = 0;
    stop_req = 1; wait_req = 1; tick();
    check("R12/R6 stop entry pll", act_out(), 7'b000_10_10);
    stop_req = 0; wait_req = 0; tick();
    check("R6 osc one cycle later", act_out(), 7'b000_11_10);
    tick(2);
    check("R4 stop held", act_out(), 7'b000_11_10);
    // R7 exit ordering via scan debug wake
    wake_dbg_scan = 1; tick(2);
    check("R10 stop not yet left", act_out(), 7'b000_11_10);
    tick();
    check("R7 osc released first", act_out(), 7'b000_10_10);
    wake_dbg_scan = 0; tick();
    check("R7 pll released", act_out(), 7'b000_00_10);
    tick(3);
    check("R7 settling", act_out(), 7'b000_00_10);
    tick();
    check("R7 back to run", act_out(), 7'b111_00_00);
    tick(2);

    // R8 fast stop, woken by pin
    fast_stop = 1; stop_req = 1; tick();
    check("R8 fast entry", act_out(), 7'b000_00_10);
    stop_req = 0; tick(2);
    check("R8 fast held", act_out(), 7'b000_00_10);
    wake_dbg_pin = 1; tick(3);
    check("R9 pin wake", act_out(), 7'b111_00_00);
    wake_dbg_pin = 0; tick(3);

    // R11 abort during entry
    fast_stop = 0; wake_irq = 1; tick();
    stop_req = 1; tick();
    check("R11 entry cycle", act_out(), 7'b000_10_10);
    stop_req = 0; tick();
    check("R11 aborted", act_out(), 7'b111_00_00);
    wake_irq = 0; tick(3);

    // seeded random traffic, checked every cycle by the model
    for (int c = 0; c < 4000; c++) begin
      core_stall    = ($urandom % 10) < 3;
      stop_req      = ($urandom % 12) == 0;
      wait_req      = ($urandom % 10) == 0;
      stop_dis      = ($urandom % 8) == 0;
      wait_dis      = ($urandom % 8) == 0;
      fast_stop     = $urandom % 2;
      settle_cycles = 8'($urandom % 6);
      wake_irq      = ($urandom % 30) == 0;
      wake_dbg_scan = ($urandom % 40) == 0;
      wake_dbg_pin  = ($urandom % 40) == 0;
      tick();
    end
    finish_run();
  end
endmodule